// File: doc/BRIEF.md
# Host-Commanded Cell Balancing Controller

This block sits in a 16-cell battery monitor and turns host subcommands into a per-cell balance enable mask. The host can name the cells directly with a bitmask, or it can give a voltage threshold in millivolts. In threshold mode the block picks, once a second, the single highest cell that lies above that threshold. Balancing always ends on its own once a configured number of one-second ticks has passed without a fresh balancing command. This stops a silent host from leaving bleed resistors switched on for good.

Alongside the mask, the block keeps a session timer and a saturating cumulative balance time for every cell. The host reads these back through the same subcommand port: the session seconds as one word, and the per-cell totals as two blocks of eight 32-bit words. The totals are cleared on a device reset and whenever configuration-update mode is entered. A configuration bit can lock out every balancing subcommand. A write is taken only when its checksum and length are correct.

Top module: `cell_bal_ctrl`

## Requirements
- R1: An accepted write of code 0x0083 drives `balance_en_o` with the 16-bit data (bit i = cell i+1) on the clock edge that takes the command. A data value of 0x0000 switches every cell off.
- R2: A read of code 0x0083 returns the current mask in `rsp_data_o[15:0]`. A read of code 0x0084 returns the stored threshold there. The response appears with `rsp_valid_o` high one cycle after the request.
- R3: An accepted write of code 0x0084 stores the threshold. The mask then holds at most one bit: the cell with the highest reading strictly above the threshold. Among equal readings the lowest index wins. If no cell is above the threshold, the mask is zero.
- R4: While threshold mode is active, the selection of R3 is recomputed from the present readings on every `sec_tick_i`.
- R5: While balancing is active, each tick advances the session timer. On the tick where the timer reaches `cfg_interval_i`, the mask clears and balancing stops.
- R6: Any accepted balancing write (0x0083 or 0x0084) sets the session timer to zero.
- R7: A read of code 0x0085 returns the 16-bit session timer. `sess_sec_o` shows the same value.
- R8: Each tick adds one to the cumulative time of every cell whose mask bit was set. A read of 0x0086 returns cells 1-8 and a read of 0x0087 returns cells 9-16, with the lowest cell of the group in bits [31:0] and each following cell 32 bits higher.
- R9: A cumulative counter stops at its all-ones value instead of wrapping.
- R10: All cumulative times go to zero after `dev_reset_i`, or after a rising edge of `cfg_update_i`. `dev_reset_i` also clears the mask, the threshold, the timer and the mode.
- R11: While `cb_no_cmd_i` is high, requests with codes 0x0083-0x0087 have no effect and get no response.
- R12: A write is discarded, leaving all state unchanged, unless its checksum equals the bitwise inverse of the 8-bit sum of the two code bytes and the two data bytes, and its length equals 6.
- R13: After `rst_n` is released, the mask, the timer, the cumulative times and `rsp_valid_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_reset_i | input | 1 | Synchronous device-reset flag; clears all state |
| cfg_update_i | input | 1 | Configuration-update mode; its rising edge clears the cumulative times |
| cb_no_cmd_i | input | 1 | Locks out the balancing subcommands |
| sec_tick_i | input | 1 | One-cycle pulse each second |
| cfg_interval_i | input | 16 | Balancing timeout in seconds |
| cell_mv_i | input | 256 | Cell readings in mV, cell i in bits [16i+15:16i] |
| cmd_valid_i | input | 1 | Subcommand request strobe |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_code_i | input | 16 | Subcommand code |
| cmd_data_i | input | 16 | Write data |
| cmd_csum_i | input | 8 | Write checksum |
| cmd_len_i | input | 8 | Write length |
| rsp_valid_o | output | 1 | Read response strobe |
| rsp_data_o | output | 256 | Read response block |
| balance_en_o | output | 16 | Per-cell balance enable |
| sess_sec_o | output | 16 | Session timer in seconds |
| cum_time_o | output | 512 | Cumulative seconds, cell i in bits [32i+31:32i] |

## Verification
Threshold selection is tested with two cells tied at the top value, one cell below them, and a cell that then rises past both. A design that compares with greater-or-equal, or scans the cells from the top down, would pick the wrong tie winner. A design that skips the per-tick re-evaluation would keep the old cell. The timeout is tested at the exact boundary tick, and again with a command sent in the middle of a session. An off-by-one stops one tick early or late, and a missing timer reset ends the second session too soon. Checksum and length errors, the lockout bit, cumulative group ordering, a narrow-counter build pushed past its maximum, and both clear sources are each tested on their own. This catches wrapped counters, swapped groups, and writes taken when they should be refused.

// File: rtl/cb_pkg.sv
package cb_pkg;

  typedef enum logic [1:0] {
    BAL_OFF   = 2'd0,
    BAL_MASK  = 2'd1,
    BAL_LEVEL = 2'd2
  } bal_mode_e;

  localparam logic [15:0] CODE_MASK   = 16'h0083;
  localparam logic [15:0] CODE_LEVEL  = 16'h0084;
  localparam logic [15:0] CODE_SESS   = 16'h0085;
  localparam logic [15:0] CODE_GRP0   = 16'h0086;
  localparam logic [15:0] CODE_LAST   = 16'h0087;
  localparam logic [7:0]  WR_DATA_BYTES = 8'd2;
  localparam logic [7:0]  WR_LEN        = WR_DATA_BYTES + 8'd4;

  // Inverted 8-bit sum over code and data bytes.
  function automatic logic [7:0] frame_csum(input logic [15:0] code,
                                            input logic [15:0] data);
    logic [7:0] acc;
    acc = code[7:0] + code[15:8] + data[7:0] + data[15:8];
    return ~acc;
  endfunction

  // Saturating increment for a counter of arbitrary width.
  function automatic logic [63:0] sat_inc(input logic [63:0] v,
                                          input logic [63:0] vmax);
    return (v >= vmax) ? vmax : v + 64'd1;
  endfunction

endpackage

// File: rtl/cb_cmd_decode.sv
module cb_cmd_decode
  import cb_pkg::*;
(
  input  logic        cmd_valid,
  input  logic        cmd_write,
  input  logic [15:0] cmd_code,
  input  logic [15:0] cmd_data,
  input  logic [7:0]  cmd_csum,
  input  logic [7:0]  cmd_len,
  input  logic        lockout,
  output logic        wr_mask_evt,
  output logic        wr_level_evt,
  output logic        rd_evt,
  output logic        frame_ok
);

  logic in_range;
  logic live;

  assign in_range = (cmd_code >= CODE_MASK) && (cmd_code <= CODE_LAST);
  assign live     = cmd_valid && in_range && !lockout;
  assign frame_ok = (cmd_csum == frame_csum(cmd_code, cmd_data)) &&
                    (cmd_len == WR_LEN);

  assign wr_mask_evt  = live && cmd_write && frame_ok && (cmd_code == CODE_MASK);
  assign wr_level_evt = live && cmd_write && frame_ok && (cmd_code == CODE_LEVEL);
  assign rd_evt       = live && !cmd_write;

endmodule

// File: rtl/cb_session.sv
module cb_session
  import cb_pkg::*;
#(
  parameter int N_CELLS = 16,
  parameter int MV_W    = 16,
  parameter int TMR_W   = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    dev_reset,
  input  logic                    sec_tick,
  input  logic [TMR_W-1:0]        interval,
  input  logic [N_CELLS*MV_W-1:0] cell_mv,
  input  logic                    wr_mask_evt,
  input  logic                    wr_level_evt,
  input  logic [15:0]             wr_data,
  output logic [N_CELLS-1:0]      mask,
  output logic [MV_W-1:0]         thr,
  output logic [TMR_W-1:0]        sess,
  output bal_mode_e               mode,
  output logic                    timeout_evt
);

  // Highest reading strictly above the threshold; the lower index keeps a tie.
  function automatic logic [N_CELLS-1:0] pick_top(
      input logic [N_CELLS*MV_W-1:0] mv, input logic [MV_W-1:0] level);
    logic [MV_W-1:0]    best;
    logic               found;
    logic [N_CELLS-1:0] sel;
    best  = '0;
    found = 1'b0;
    sel   = '0;
    for (int i = 0; i < N_CELLS; i++) begin
      if (mv[i*MV_W +: MV_W] > level && (!found || mv[i*MV_W +: MV_W] > best)) begin
        found  = 1'b1;
        best   = mv[i*MV_W +: MV_W];
        sel    = '0;
        sel[i] = 1'b1;
      end
    end
    return sel;
  endfunction

  logic [TMR_W:0]     sess_next;
  logic               active;
  logic [N_CELLS-1:0] pick_new;
  logic [N_CELLS-1:0] pick_cur;

  assign active      = (mode != BAL_OFF);
  assign sess_next   = {1'b0, sess} + 1'b1;
  assign timeout_evt = sec_tick && active && !wr_mask_evt && !wr_level_evt &&
                       (sess_next >= {1'b0, interval});
  assign pick_new    = pick_top(cell_mv, wr_data[MV_W-1:0]);
  assign pick_cur    = pick_top(cell_mv, thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      thr  <= '0;
      sess <= '0;
      mode <= BAL_OFF;
    end else if (dev_reset) begin
      mask <= '0;
      thr  <= '0;
      sess <= '0;
      mode <= BAL_OFF;
    end else if (wr_mask_evt) begin
      sess <= '0;
      mask <= wr_data[N_CELLS-1:0];
      mode <= (wr_data[N_CELLS-1:0] == '0) ? BAL_OFF : BAL_MASK;
    end else if (wr_level_evt) begin
      sess <= '0;
      thr  <= wr_data[MV_W-1:0];
      mask <= pick_new;
      mode <= BAL_LEVEL;
    end else if (sec_tick && active) begin
      sess <= sess_next[TMR_W-1:0];
      if (timeout_evt) begin
        mask <= '0;
        mode <= BAL_OFF;
      end else if (mode == BAL_LEVEL) begin
        mask <= pick_cur;
      end
    end
  end

endmodule

// File: rtl/cb_cum_timers.sv
module cb_cum_timers
  import cb_pkg::*;
#(
  parameter int N_CELLS = 16,
  parameter int CUM_W   = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dev_reset,
  input  logic                     cfg_update,
  input  logic                     sec_tick,
  input  logic [N_CELLS-1:0]       mask,
  output logic [N_CELLS*CUM_W-1:0] cum_flat,
  output logic                     clear_evt
);

  localparam logic [CUM_W-1:0] CUM_MAX = '1;

  logic cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= 1'b0;
    else        cfg_q <= cfg_update;
  end

  assign clear_evt = dev_reset || (cfg_update && !cfg_q);

  for (genvar c = 0; c < N_CELLS; c++) begin : g_cell
    logic [CUM_W-1:0] cnt;
    logic [63:0]      nxt;

    assign nxt = sat_inc(64'(cnt), 64'(CUM_MAX));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt <= '0;
      else if (clear_evt)          cnt <= '0;
      else if (sec_tick && mask[c]) cnt <= nxt[CUM_W-1:0];
    end

    assign cum_flat[c*CUM_W +: CUM_W] = cnt;
  end

endmodule

// File: rtl/cell_bal_ctrl.sv
module cell_bal_ctrl
  import cb_pkg::*;
#(
  parameter int N_CELLS = 16,
  parameter int MV_W    = 16,
  parameter int CUM_W   = 32,
  parameter int GROUP   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dev_reset_i,
  input  logic                     cfg_update_i,
  input  logic                     cb_no_cmd_i,
  input  logic                     sec_tick_i,
  input  logic [15:0]              cfg_interval_i,
  input  logic [N_CELLS*MV_W-1:0]  cell_mv_i,
  input  logic                     cmd_valid_i,
  input  logic                     cmd_write_i,
  input  logic [15:0]              cmd_code_i,
  input  logic [15:0]              cmd_data_i,
  input  logic [7:0]               cmd_csum_i,
  input  logic [7:0]               cmd_len_i,
  output logic                     rsp_valid_o,
  output logic [GROUP*CUM_W-1:0]   rsp_data_o,
  output logic [N_CELLS-1:0]       balance_en_o,
  output logic [15:0]              sess_sec_o,
  output logic [N_CELLS*CUM_W-1:0] cum_time_o
);

  localparam int RSP_W    = GROUP * CUM_W;
  localparam int N_GROUPS = N_CELLS / GROUP;

  logic               wr_mask_evt;
  logic               wr_level_evt;
  logic               rd_evt;
  logic               frame_ok;
  logic               cmd_wr_accept;
  logic               timeout_evt;
  logic               clear_evt;
  logic [N_CELLS-1:0] mask_w;
  logic [MV_W-1:0]    thr_w;
  logic [15:0]        sess_w;
  bal_mode_e          mode_w;
  logic [N_CELLS*CUM_W-1:0] cum_w;
  logic [RSP_W-1:0]   rsp_d;

  cb_cmd_decode u_dec (
    .cmd_valid    (cmd_valid_i),
    .cmd_write    (cmd_write_i),
    .cmd_code     (cmd_code_i),
    .cmd_data     (cmd_data_i),
    .cmd_csum     (cmd_csum_i),
    .cmd_len      (cmd_len_i),
    .lockout      (cb_no_cmd_i),
    .wr_mask_evt  (wr_mask_evt),
    .wr_level_evt (wr_level_evt),
    .rd_evt       (rd_evt),
    .frame_ok     (frame_ok)
  );

  assign cmd_wr_accept = wr_mask_evt || wr_level_evt;

  cb_session #(.N_CELLS(N_CELLS), .MV_W(MV_W), .TMR_W(16)) u_sess (
    .clk          (clk),
    .rst_n        (rst_n),
    .dev_reset    (dev_reset_i),
    .sec_tick     (sec_tick_i),
    .interval     (cfg_interval_i),
    .cell_mv      (cell_mv_i),
    .wr_mask_evt  (wr_mask_evt),
    .wr_level_evt (wr_level_evt),
    .wr_data      (cmd_data_i),
    .mask         (mask_w),
    .thr          (thr_w),
    .sess         (sess_w),
    .mode         (mode_w),
    .timeout_evt  (timeout_evt)
  );

  cb_cum_timers #(.N_CELLS(N_CELLS), .CUM_W(CUM_W)) u_cum (
    .clk        (clk),
    .rst_n      (rst_n),
    .dev_reset  (dev_reset_i),
    .cfg_update (cfg_update_i),
    .sec_tick   (sec_tick_i),
    .mask       (mask_w),
    .cum_flat   (cum_w),
    .clear_evt  (clear_evt)
  );

  // Read-back multiplexer.
  always_comb begin
    rsp_d = '0;
    unique case (cmd_code_i)
      CODE_MASK:  rsp_d[N_CELLS-1:0] = mask_w;
      CODE_LEVEL: rsp_d[MV_W-1:0]    = thr_w;
      CODE_SESS:  rsp_d[15:0]        = sess_w;
      default: begin
        for (int g = 0; g < N_GROUPS; g++) begin
          if (cmd_code_i == CODE_GRP0 + 16'(g)) rsp_d = cum_w[g*RSP_W +: RSP_W];
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= rd_evt;
      if (rd_evt) rsp_data_o <= rsp_d;
    end
  end

  assign balance_en_o = mask_w;
  assign sess_sec_o   = sess_w;
  assign cum_time_o   = cum_w;

endmodule

// File: rtl/cell_bal_ctrl_checker.sv
module cell_bal_ctrl_checker
  import cb_pkg::*;
#(
  parameter int N_CELLS = 16,
  parameter int CUM_W   = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     dev_reset_i,
  input logic                     cb_no_cmd_i,
  input logic                     cmd_valid_i,
  input logic                     sec_tick_i,
  input logic [15:0]              cfg_interval_i,
  input logic                     rsp_valid_o,
  input logic [N_CELLS-1:0]       balance_en_o,
  input logic [15:0]              sess_sec_o,
  input logic [N_CELLS*CUM_W-1:0] cum_time_o,
  input bal_mode_e                mode_w,
  input logic                     cmd_wr_accept,
  input logic                     clear_evt
);

  assert_level_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_w == BAL_LEVEL |-> $onehot0(balance_en_o));

  assert_timer_below_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w != BAL_OFF && cfg_interval_i != 16'd0) |-> sess_sec_o < cfg_interval_i);

  assert_cmd_zero_timer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_accept && !dev_reset_i) |=> sess_sec_o == 16'd0);

  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_evt |=> cum_time_o[CUM_W-1:0] >= $past(cum_time_o[CUM_W-1:0]));

  assert_clear_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear_evt |=> cum_time_o == '0);

  assert_lockout_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cb_no_cmd_i && cmd_valid_i && !sec_tick_i && !dev_reset_i) |=> $stable(balance_en_o));

  assert_lockout_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cb_no_cmd_i && cmd_valid_i) |=> !rsp_valid_o);

endmodule

bind cell_bal_ctrl cell_bal_ctrl_checker #(.N_CELLS(N_CELLS), .CUM_W(CUM_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .dev_reset_i    (dev_reset_i),
  .cb_no_cmd_i    (cb_no_cmd_i),
  .cmd_valid_i    (cmd_valid_i),
  .sec_tick_i     (sec_tick_i),
  .cfg_interval_i (cfg_interval_i),
  .rsp_valid_o    (rsp_valid_o),
  .balance_en_o   (balance_en_o),
  .sess_sec_o     (sess_sec_o),
  .cum_time_o     (cum_time_o),
  .mode_w         (mode_w),
  .cmd_wr_accept  (cmd_wr_accept),
  .clear_evt      (clear_evt)
);

// File: tb/test_cell_bal_ctrl.sv
module test_cell_bal_ctrl;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         dev_reset = 1'b0;
  logic         cfg_update = 1'b0;
  logic         no_cmd = 1'b0;
  logic         tick = 1'b0;
  logic [15:0]  interval = 16'd100;
  logic [255:0] mv = '0;
  logic         cv = 1'b0;
  logic         cw = 1'b0;
  logic [15:0]  code = '0;
  logic [15:0]  data = '0;
  logic [7:0]   csum = '0;
  logic [7:0]   len = '0;

  logic         rsp_valid;
  logic [255:0] rsp_data;
  logic [15:0]  bal_en;
  logic [15:0]  sess;
  logic [511:0] cum;

  logic         s_rsp_valid;
  logic [31:0]  s_rsp_data;
  logic [15:0]  s_bal_en;
  logic [15:0]  s_sess;
  logic [63:0]  s_cum;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cell_bal_ctrl i_cell_bal_ctrl (
    .clk(clk), .rst_n(rst_n), .dev_reset_i(dev_reset), .cfg_update_i(cfg_update),
    .cb_no_cmd_i(no_cmd), .sec_tick_i(tick), .cfg_interval_i(interval), .cell_mv_i(mv),
    .cmd_valid_i(cv), .cmd_write_i(cw), .cmd_code_i(code), .cmd_data_i(data),
    .cmd_csum_i(csum), .cmd_len_i(len), .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .balance_en_o(bal_en), .sess_sec_o(sess), .cum_time_o(cum)
  );

  // Narrow-counter build for the saturation check.
  cell_bal_ctrl #(.CUM_W(4)) i_sat (
    .clk(clk), .rst_n(rst_n), .dev_reset_i(dev_reset), .cfg_update_i(cfg_update),
    .cb_no_cmd_i(no_cmd), .sec_tick_i(tick), .cfg_interval_i(interval), .cell_mv_i(mv),
    .cmd_valid_i(cv), .cmd_write_i(cw), .cmd_code_i(code), .cmd_data_i(data),
    .cmd_csum_i(csum), .cmd_len_i(len), .rsp_valid_o(s_rsp_valid), .rsp_data_o(s_rsp_data),
    .balance_en_o(s_bal_en), .sess_sec_o(s_sess), .cum_time_o(s_cum)
  );

  task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] good_sum(input logic [15:0] c, input logic [15:0] d);
    int s;
    s = int'(c[15:8]) + int'(c[7:0]) + int'(d[15:8]) + int'(d[7:0]);
    return 8'hFF - 8'(s % 256);
  endfunction

  task automatic wr(input logic [15:0] c, input logic [15:0] d,
                    input logic [7:0] sum_xor = 8'h00, input logic [7:0] l = 8'd6);
    @(negedge clk);
    cv = 1'b1; cw = 1'b1; code = c; data = d;
    csum = good_sum(c, d) ^ sum_xor; len = l;
    @(negedge clk);
    cv = 1'b0; cw = 1'b0;
  endtask

  task automatic rd(input logic [15:0] c, output logic got, output logic [255:0] val);
    @(negedge clk);
    cv = 1'b1; cw = 1'b0; code = c;
    @(negedge clk);
    cv = 1'b0;
    got = rsp_valid; val = rsp_data;
  endtask

  task automatic sec();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic pulse_dev_reset();
    @(negedge clk); dev_reset = 1'b1;
    @(negedge clk); dev_reset = 1'b0;
  endtask

  task automatic set_cell(input int idx, input logic [15:0] v);
    mv[idx*16 +: 16] = v;
  endtask

  task automatic t_reset();
    chk("R13 mask", 512'(bal_en), 512'h0);
    chk("R13 timer", 512'(sess), 512'h0);
    chk("R13 cum", cum, 512'h0);
    chk("R13 rsp", 512'(rsp_valid), 512'h0);
  endtask

  task automatic t_mask();
    logic g; logic [255:0] v;
    wr(16'h0083, 16'h1234);
    chk("R1 mask set", 512'(bal_en), 512'h1234);
    rd(16'h0083, g, v);
    chk("R2 mask read valid", 512'(g), 512'h1);
    chk("R2 mask read", 512'(v), 512'h1234);
    wr(16'h0083, 16'h0000);
    chk("R1 mask off", 512'(bal_en), 512'h0);
  endtask

  task automatic t_bad_frame();
    wr(16'h0083, 16'h00FF, 8'h01, 8'd6);
    chk("R12 bad checksum", 512'(bal_en), 512'h0);
    wr(16'h0083, 16'h00FF, 8'h00, 8'd5);
    chk("R12 bad length", 512'(bal_en), 512'h0);
  endtask

  task automatic t_level();
    logic g; logic [255:0] v;
    mv = '0;
    set_cell(3, 16'd3800); set_cell(7, 16'd3900); set_cell(10, 16'd3900);
    set_cell(12, 16'd3700);
    wr(16'h0084, 16'd3700);
    chk("R3 tie to lower index", 512'(bal_en), 512'h0080);
    rd(16'h0084, g, v);
    chk("R2 threshold read", 512'(v), 512'd3700);
    set_cell(12, 16'd4000);
    chk("R4 no change before tick", 512'(bal_en), 512'h0080);
    sec();
    chk("R4 re-evaluated on tick", 512'(bal_en), 512'h1000);
    mv = '0;
    sec();
    chk("R3 none above threshold", 512'(bal_en), 512'h0);
    wr(16'h0083, 16'h0000);
  endtask

  task automatic t_timeout();
    logic g; logic [255:0] v;
    interval = 16'd5;
    wr(16'h0083, 16'h0003);
    for (int i = 0; i < 4; i++) sec();
    chk("R5 still on before limit", 512'(bal_en), 512'h0003);
    chk("R7 timer", 512'(sess), 512'd4);
    sec();
    chk("R5 off at limit", 512'(bal_en), 512'h0);
    rd(16'h0085, g, v);
    chk("R7 session read", 512'(v), 512'd5);
    wr(16'h0083, 16'h0001);
    for (int i = 0; i < 3; i++) sec();
    wr(16'h0083, 16'h0001);
    chk("R6 timer cleared", 512'(sess), 512'd0);
    for (int i = 0; i < 4; i++) sec();
    chk("R6 session extended", 512'(bal_en), 512'h0001);
    wr(16'h0083, 16'h0000);
    interval = 16'd100;
  endtask

  task automatic t_cum();
    logic g; logic [255:0] v;
    pulse_dev_reset();
    wr(16'h0083, 16'h8101);
    for (int i = 0; i < 3; i++) sec();
    rd(16'h0086, g, v);
    chk("R8 group low", 512'(v), 512'd3);
    rd(16'h0087, g, v);
    chk("R8 group high", 512'(v), {256'h0, 32'd3, 192'h0, 32'd3});
    @(negedge clk); cfg_update = 1'b1;
    @(negedge clk);
    chk("R10 cfg entry clears", cum, 512'h0);
    chk("R10 cfg keeps mask", 512'(bal_en), 512'h8101);
    sec();
    chk("R10 counts while held", 512'(cum[31:0]), 512'd1);
    @(negedge clk); cfg_update = 1'b0;
    pulse_dev_reset();
    chk("R10 dev reset clears cum", cum, 512'h0);
    chk("R10 dev reset clears mask", 512'(bal_en), 512'h0);
  endtask

  task automatic t_lockout();
    logic g; logic [255:0] v;
    wr(16'h0083, 16'h0002);
    no_cmd = 1'b1;
    wr(16'h0083, 16'h00F0);
    chk("R11 write ignored", 512'(bal_en), 512'h0002);
    rd(16'h0083, g, v);
    chk("R11 no response", 512'(g), 512'h0);
    no_cmd = 1'b0;
    wr(16'h0083, 16'h0000);
  endtask

  task automatic t_saturate();
    pulse_dev_reset();
    wr(16'h0083, 16'h0001);
    for (int i = 0; i < 18; i++) sec();
    chk("R9 saturates", 512'(s_cum[3:0]), 512'hF);
    chk("R9 wide counter", 512'(cum[31:0]), 512'd18);
    wr(16'h0083, 16'h0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_bad_frame();
    t_level();
    t_timeout();
    t_cum();
    t_lockout();
    t_saturate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule